// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a 32-bit virtual address from one process into a 14-bit physical address. It uses a flat page table in memory, indexed directly by virtual page number. A requester raises `req` with an address and a write flag. The block then works through four steps:

- It latches the request.
- It forms the entry address from a table base plus four times the page number.
- It reads that one 32-bit entry through a valid/ready read port and waits for the response.
- It decides the outcome.

A usable entry ends in `done` with the physical page number placed above the untouched 12-bit offset. A missing entry, or a write to a read-only page, ends in `fault` with a cause code and the page number that failed. Either result stays on the outputs until the requester drops `req`. Once software has fixed the entry, the requester retries the same access.

Entry layout:

| Bits | Meaning |
|------|---------|
| 0 | present |
| 1 | writable |
| 3:2 | physical page number |
| 7:4 | process generation tag |
| 31:8 | ignored |

The block keeps a generation counter that starts at 0 after reset. Each pulse on `flush` increments it, wrapping modulo 16. An entry whose tag differs from the counter counts as not present. So one pulse makes every entry of the old table stale, which is how a new process starts with nothing mapped under demand paging.

Control is one state machine with five states:

| State | Meaning |
|-------|---------|
| IDLE | waiting for a request |
| ISSUE | read request offered on the port |
| WAIT | read accepted, response pending |
| DONE | translation result presented |
| FAULT | fault result presented |

Transitions:

| Transition | Taken when |
|------------|------------|
| IDLE→ISSUE | `req` is seen |
| ISSUE→WAIT | `mem_rd_ready` is high |
| WAIT→DONE | the response is usable |
| WAIT→FAULT | the response is not present or not permitted |
| DONE→IDLE, FAULT→IDLE | `req` is low |

Top module: `pt_translator`

## Requirements
- R1: After reset `done`, `fault` and `mem_rd_valid` are low and `pa`, `fault_cause` and `fault_vpn` read zero.
- R2: The entry read address is `pt_base + (va[31:12] << 2)`, modulo 2^32, using the values of `pt_base` and `va` seen when the request is taken.
- R3: When the entry is present, carries the current generation tag and the access is permitted, `done` rises and `pa` = {entry[3:2], va[11:0]}. Entry bits 31:8 have no effect on the result.
- R4: When entry bit 0 is 0, `fault` rises with `fault_cause` = 2'b01 and `fault_vpn` = va[31:12]. `done` stays low and `pa` reads zero.
- R5: A write (`wr`=1) to a present entry with bit 1 clear faults with `fault_cause` = 2'b10. A read of that entry, or a write to an entry with bit 1 set, translates normally.
- R6: While `req` stays high after a result, that result holds unchanged. `done` and `fault` are low from the first clock edge that samples `req` low.
- R7: Each request makes exactly one table read. `mem_rd_valid` stays high with a stable address until `mem_rd_ready`, and no read is offered while a result is shown.
- R8: A request that faulted translates successfully when retried after the table entry has been made present.
- R9: The generation starts at 0 and each `flush` pulse adds 1 modulo 16. An entry whose bits 7:4 differ from the generation faults as not present (cause 2'b01).
- R10: The result appears on the clock edge right after the edge that samples `mem_rsp_valid` high, whatever the read latency or the stall before acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| flush | input | 1 | one-cycle pulse: move to the next process generation |
| pt_base | input | 32 | byte address of the page table |
| req | input | 1 | translation request, held until the result is taken |
| va | input | 32 | virtual address |
| wr | input | 1 | 1 for a store access, 0 for a load |
| done | output | 1 | translation succeeded |
| pa | output | 14 | physical address, valid with `done` |
| fault | output | 1 | page fault raised |
| fault_cause | output | 2 | 01 not present, 10 protection |
| fault_vpn | output | 20 | page number that faulted |
| mem_rd_valid | output | 1 | table read request |
| mem_rd_addr | output | 32 | table entry address |
| mem_rd_ready | input | 1 | table read accepted |
| mem_rsp_valid | input | 1 | table entry returned |
| mem_rsp_data | input | 32 | table entry word |

## Verification
Timing of a request, by clock edge:

- The first edge that sees `req` moves the block to ISSUE, so `mem_rd_valid` shows one edge later.
- The read is accepted on the edge where `mem_rd_ready` is high.
- The result registers on the edge after the response edge.

The bench's memory model records the cycle in which it drives the response and the cycle in which it first sees a result, and requires exactly one cycle between them for every latency and stall it applies. All outputs are sampled on falling edges. The bench confirms that the result holds for two more cycles with `req` high, then drops `req` and expects both result flags low at the next falling edge.

// File: rtl/pt_pkg.sv
package pt_pkg;

    // Fault cause codes presented on fault_cause
    typedef enum logic [1:0] {
        CAUSE_NONE        = 2'b00,
        CAUSE_NOT_PRESENT = 2'b01,
        CAUSE_PROTECT     = 2'b10
    } fault_cause_e;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } xlat_state_e;

endpackage

// File: rtl/pt_gen_counter.sv
module pt_gen_counter #(
    parameter int GEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    output logic [GEN_W-1:0] gen
);

    logic [GEN_W-1:0] gen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else if (flush) begin
            gen_q <= gen_q + 1'b1;
        end
    end

    assign gen = gen_q;

    AST_GEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> gen == $past(gen) + 1'b1); // R9
    AST_GEN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> $stable(gen)); // R9

endmodule

// File: rtl/pt_va_split.sv
module pt_va_split #(
    parameter int VA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int ADDR_W = 32
) (
    input  logic [VA_W-1:0]       va,
    input  logic [ADDR_W-1:0]     pt_base,
    output logic [VA_W-OFF_W-1:0] vpn,
    output logic [OFF_W-1:0]      offset,
    output logic [ADDR_W-1:0]     pte_addr
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PAD_W = ADDR_W - VPN_W - 2;

    assign vpn      = va[VA_W-1:OFF_W];
    assign offset   = va[OFF_W-1:0];
    // Four bytes per entry
    assign pte_addr = pt_base + {{PAD_W{1'b0}}, vpn, 2'b00};

endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode
    import pt_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PPN_W = 2,
    parameter int GEN_W = 4
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [GEN_W-1:0] cur_gen,
    input  logic             is_write,
    output fault_cause_e     verdict,
    output logic [PPN_W-1:0] ppn
);

    localparam int PRESENT_BIT = 0;
    localparam int WRITE_BIT   = 1;
    localparam int PPN_LSB     = 2;
    localparam int GEN_LSB     = PPN_LSB + PPN_W;

    logic             present;
    logic             writable;
    logic [GEN_W-1:0] tag;

    always_comb begin
        present  = pte[PRESENT_BIT];
        writable = pte[WRITE_BIT];
        tag      = pte[GEN_LSB +: GEN_W];
        ppn      = pte[PPN_LSB +: PPN_W];
        if (!present || (tag != cur_gen)) begin
            verdict = CAUSE_NOT_PRESENT;
        end else if (is_write && !writable) begin
            verdict = CAUSE_PROTECT;
        end else begin
            verdict = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/pt_translator.sv
module pt_translator
    import pt_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 14,
    parameter int PTE_W  = 32,
    parameter int ADDR_W = 32,
    parameter int GEN_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [ADDR_W-1:0]       pt_base,
    input  logic                    req,
    input  logic [VA_W-1:0]         va,
    input  logic                    wr,
    output logic                    done,
    output logic [PA_W-1:0]         pa,
    output logic                    fault,
    output logic [1:0]              fault_cause,
    output logic [VA_W-OFF_W-1:0]   fault_vpn,
    output logic                    mem_rd_valid,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic                    mem_rd_ready,
    input  logic                    mem_rsp_valid,
    input  logic [PTE_W-1:0]        mem_rsp_data
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    xlat_state_e state_q, state_d;

    logic [VPN_W-1:0]  vpn_w;
    logic [OFF_W-1:0]  off_w;
    logic [ADDR_W-1:0] addr_w;
    logic [GEN_W-1:0]  gen_w;
    fault_cause_e      verdict_w;
    logic [PPN_W-1:0]  ppn_w;

    logic [VPN_W-1:0]  vpn_q;
    logic [OFF_W-1:0]  off_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [PA_W-1:0]   pa_q;
    fault_cause_e      cause_q;

    logic take_req;
    logic rsp_seen;

    pt_va_split #(
        .VA_W   (VA_W),
        .OFF_W  (OFF_W),
        .ADDR_W (ADDR_W)
    ) u_split (
        .va       (va),
        .pt_base  (pt_base),
        .vpn      (vpn_w),
        .offset   (off_w),
        .pte_addr (addr_w)
    );

    pt_gen_counter #(
        .GEN_W (GEN_W)
    ) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .gen   (gen_w)
    );

    pt_pte_decode #(
        .PTE_W (PTE_W),
        .PPN_W (PPN_W),
        .GEN_W (GEN_W)
    ) u_decode (
        .pte      (mem_rsp_data),
        .cur_gen  (gen_w),
        .is_write (wr_q),
        .verdict  (verdict_w),
        .ppn      (ppn_w)
    );

    assign take_req = (state_q == ST_IDLE) && req;
    assign rsp_seen = (state_q == ST_WAIT) && mem_rsp_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (mem_rd_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = (verdict_w == CAUSE_NONE) ? ST_DONE : ST_FAULT;
                end
            end
            ST_DONE: begin
                if (!req) state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (!req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            off_q   <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            pa_q    <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            if (take_req) begin
                vpn_q  <= vpn_w;
                off_q  <= off_w;
                addr_q <= addr_w;
                wr_q   <= wr;
            end
            if (rsp_seen) begin
                cause_q <= verdict_w;
                pa_q    <= (verdict_w == CAUSE_NONE) ? {ppn_w, off_q} : '0;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        done         = 1'b0;
        fault        = 1'b0;
        pa           = '0;
        fault_cause  = CAUSE_NONE;
        fault_vpn    = '0;
        mem_rd_valid = 1'b0;
        mem_rd_addr  = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ISSUE: begin
                mem_rd_valid = 1'b1;
                mem_rd_addr  = addr_q;
            end
            ST_WAIT: begin
            end
            ST_DONE: begin
                done = 1'b1;
                pa   = pa_q;
            end
            ST_FAULT: begin
                fault       = 1'b1;
                fault_cause = cause_q;
                fault_vpn   = vpn_q;
            end
            default: begin
            end
        endcase
    end

    AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R3
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause != 2'b00) && (pa == '0)); // R4
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr)); // R7
    AST_NO_RD_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> !mem_rd_valid); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || fault) && req) |=> $stable(done) && $stable(fault) && $stable(pa)
                                   && $stable(fault_cause) && $stable(fault_vpn)); // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || fault) && !req) |=> !done && !fault); // R6
    AST_RESULT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid) |=> (done || fault)); // R10

endmodule

// File: tb/tb_pt_translator.sv
`timescale 1ns/1ps
module tb_pt_translator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] pt_base = 32'h0040_0000;
    logic        req = 1'b0;
    logic [31:0] va = '0;
    logic        wr = 1'b0;
    logic        done;
    logic [13:0] pa;
    logic        fault;
    logic [1:0]  fault_cause;
    logic [19:0] fault_vpn;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_err = 0;

    // Memory model state
    logic [31:0] ptm [logic [31:0]];
    int          cyc = 0;
    int          cnt = 0;
    int          mem_lat = 1;
    int          stall_left = 0;
    bit          in_flight = 0;
    int          issue_cyc = 0;
    int          n_reads = 0;
    int          extra = 0;
    int          rsp_cyc = 0;
    int          res_cyc = 0;
    logic [31:0] issued_addr = '0;
    logic [3:0]  cur_gen = '0;

    always #5 clk = ~clk;

    pt_translator dut (
        .clk (clk), .rst_n (rst_n), .flush (flush), .pt_base (pt_base),
        .req (req), .va (va), .wr (wr),
        .done (done), .pa (pa), .fault (fault), .fault_cause (fault_cause),
        .fault_vpn (fault_vpn),
        .mem_rd_valid (mem_rd_valid), .mem_rd_addr (mem_rd_addr),
        .mem_rd_ready (mem_rd_ready), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    function automatic logic [31:0] lookup(input logic [31:0] a);
        if (ptm.exists(a)) return ptm[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] mk_pte(input bit v, input bit w, input logic [1:0] ppn,
                                           input logic [3:0] gen, input logic [23:0] junk);
        return {junk, gen, ppn, w, v};
    endfunction

    function automatic logic [31:0] ent_addr(input logic [19:0] vpn);
        return pt_base + {10'b0, vpn, 2'b00};
    endfunction

    // Table read port model, all activity on falling edges
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        mem_rd_ready  = 1'b0;
        if ((done || fault) && res_cyc == 0) res_cyc = cyc;
        if (mem_rd_valid && in_flight && cyc > issue_cyc) extra++;
        if (cnt > 0) begin
            if (cnt == 1) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = lookup(issued_addr);
                rsp_cyc       = cyc;
            end
            cnt--;
        end else if (mem_rd_valid && !in_flight) begin
            if (stall_left > 0) begin
                stall_left--;
            end else begin
                mem_rd_ready = 1'b1;
                in_flight    = 1'b1;
                issue_cyc    = cyc;
                issued_addr  = mem_rd_addr;
                n_reads++;
                cnt = mem_lat;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // kind: 0 success, 1 not present, 2 protection
    task automatic xlat(input logic [31:0] a, input bit w, input int lat, input int stall,
                        input int kind, input logic [13:0] exp_pa, input string tag);
        logic [13:0] pa_s;
        logic [1:0]  c_s;
        in_flight = 0; res_cyc = 0; rsp_cyc = 0; n_reads = 0; extra = 0;
        stall_left = stall; mem_lat = lat;
        va = a; wr = w; req = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done || fault) break;
        end
        #1;
        chk(n_reads == 1 && extra == 0, "R7", "reads per request", n_reads + extra, 1);
        chk(issued_addr == ent_addr(a[31:12]), "R2", "entry address", issued_addr, ent_addr(a[31:12]));
        chk(res_cyc == rsp_cyc + 1, "R10", "result cycle", res_cyc, rsp_cyc + 1);
        if (kind == 0) begin
            chk(done && !fault && pa == exp_pa, tag, "translated pa", {fault, done, pa}, {2'b01, exp_pa});
        end else begin
            chk(fault && !done && fault_cause == kind[1:0] && fault_vpn == a[31:12] && pa == 14'h0,
                tag, "fault cause/vpn", {done, fault, fault_cause, fault_vpn},
                {1'b0, 1'b1, kind[1:0], a[31:12]});
        end
        pa_s = pa; c_s = fault_cause;
        repeat (2) @(negedge clk);
        chk((done || fault) && pa == pa_s && fault_cause == c_s && !mem_rd_valid, "R6",
            "result hold", {pa, fault_cause}, {pa_s, c_s});
        req = 1'b0;
        @(negedge clk);
        chk(!done && !fault, "R6", "release", {done, fault}, 0);
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        cur_gen = cur_gen + 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [19:0] vl [5];
        logic [31:0] bl [2];
        vl[0] = 20'h00000; vl[1] = 20'h00001; vl[2] = 20'h12345;
        vl[3] = 20'h60000; vl[4] = 20'hFFFFF;
        bl[0] = 32'h0040_0000; bl[1] = 32'h7FFF_F000;

        repeat (3) @(negedge clk);
        chk(!done && !fault && !mem_rd_valid && pa == 0 && fault_cause == 0 && fault_vpn == 0,
            "R1", "reset outputs", {done, fault, mem_rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !fault && !mem_rd_valid, "R1", "idle after reset", {done, fault, mem_rd_valid}, 0);

        // Sweep: bases x pages x frames x writable x access kind (R3, R5)
        for (int b = 0; b < 2; b++) begin
            pt_base = bl[b];
            for (int vi = 0; vi < 5; vi++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int wb = 0; wb < 2; wb++) begin
                        for (int acc = 0; acc < 2; acc++) begin
                            logic [11:0] off;
                            logic [23:0] junk;
                            off  = 12'((vi * 613 + p * 273 + wb * 77 + acc * 5) & 32'hFFF);
                            junk = 24'((vi * 32'h9E37) ^ (p * 32'h5A5A5) ^ wb);
                            ptm[ent_addr(vl[vi])] = mk_pte(1'b1, wb[0], p[1:0], 4'h0, junk);
                            if (acc == 1 && wb == 0)
                                xlat({vl[vi], off}, 1'b1, 1 + (vi % 3), p % 3, 2, 14'h0, "R5");
                            else
                                xlat({vl[vi], off}, acc[0], 1 + (vi % 3), p % 3, 0,
                                     {p[1:0], off}, "R3");
                        end
                    end
                end
            end
        end
        pt_base = 32'h0040_0000;
        ptm.delete();

        // Not present: absent entry and cleared present bit with other fields set (R4)
        xlat(32'h1234_5678, 1'b0, 2, 0, 1, 14'h0, "R4");
        ptm[ent_addr(20'hABCDE)] = mk_pte(1'b0, 1'b1, 2'd3, 4'h0, 24'hFFFFFF);
        xlat(32'hABCD_E123, 1'b1, 1, 1, 1, 14'h0, "R4");
        xlat(32'hABCD_E123, 1'b0, 3, 2, 1, 14'h0, "R4");

        // Worked examples (R3)
        ptm[ent_addr(20'hFFFFF)] = mk_pte(1'b1, 1'b0, 2'd2, 4'h0, 24'h0);
        xlat(32'hFFFF_F004, 1'b0, 1, 0, 0, 14'h2004, "R3");

        // Fault then retry after the entry is made present (R8)
        xlat(32'h6000_0030, 1'b0, 2, 0, 1, 14'h0, "R8");
        ptm[ent_addr(20'h60000)] = mk_pte(1'b1, 1'b1, 2'd2, 4'h0, 24'h0);
        xlat(32'h6000_0030, 1'b0, 2, 0, 0, 14'h2030, "R8");
        xlat(32'h6000_0030, 1'b1, 4, 3, 0, 14'h2030, "R8");

        // Generation flush (R9)
        ptm[ent_addr(20'h00005)] = mk_pte(1'b1, 1'b1, 2'd1, 4'h0, 24'h0);
        xlat(32'h0000_5ABC, 1'b0, 1, 0, 0, 14'h1ABC, "R9");
        pulse_flush();
        xlat(32'h0000_5ABC, 1'b0, 1, 0, 1, 14'h0, "R9");
        xlat(32'h6000_0030, 1'b0, 1, 0, 1, 14'h0, "R9");
        ptm[ent_addr(20'h00005)] = mk_pte(1'b1, 1'b1, 2'd3, cur_gen, 24'h0);
        xlat(32'h0000_5ABC, 1'b0, 2, 1, 0, 14'h3ABC, "R9");
        for (int k = 0; k < 15; k++) pulse_flush();
        xlat(32'h0000_5ABC, 1'b0, 1, 0, 1, 14'h0, "R9");
        xlat(32'h6000_0030, 1'b1, 1, 0, 0, 14'h2030, "R9");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule